// File: doc/BRIEF.md
# I2C Bus State and Misplaced-Condition Monitor

This block observes already-synchronised SCL and SDA levels of an I2C bus and recognises Start and Stop conditions. Between a Start and the matching Stop it keeps a bus-busy flag. It also tracks the position of the current clock pulse inside each nine-pulse slot, which holds eight data bits and one acknowledge bit.

A Start or Stop that appears in the middle of a slot is a protocol violation. The monitor records it as a sticky bus error and raises an event flag. It handles the first clock pulse of a slot differently. A condition seen there raises no error. Instead the busy flag drops and the pulse position carries on. A Stop that follows an acknowledge lands on exactly this pulse and is therefore accepted silently.

A separate sticky retry hint reports two cases: an acknowledge slot answered with a NACK, and a busy flag dropped by a Start on the first pulse. A controller can use either one to restart its transfer. One software pulse clears all sticky flags. The interrupt request is the event flag gated by an enable input.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A Start (SDA falling while SCL stays high) sets the busy flag and sets the slot position to 0, except when it lands on pulse 1 of a busy bus. The result is visible one clock after the condition.
- R2: A Stop (SDA rising while SCL stays high) always leaves the busy flag cleared one clock later.
- R3: Each SCL rising edge advances the slot position by one. The position runs 1 to 9, and the rise after position 9 gives position 1.
- R4: While busy, a Start or Stop at slot position 2 to 9 sets the bus-error flag and the event flag. An offending Start leaves busy set; an offending Stop clears it. Either one returns the position to 0.
- R5: While busy, a Start or Stop at slot position 1 sets no bus error, clears the busy flag and leaves the position at 1.
- R6: The interrupt request equals the event flag when the interrupt-enable input is 1, and stays 0 when that input is 0.
- R7: The bus-error, retry and event flags stay set until the clear input is high at a clock edge. A set in the same cycle as the clear wins.
- R8: The retry hint and the event flag are set in two cases: SDA is high at the ninth SCL rise of a busy slot (NACK), or a Start clears busy at position 1.
- R9: With the bus idle, a Stop has no effect and a Start raises no error. On a busy bus, a Stop at position 0 (before any pulse) is legal: it clears busy with no error.
- R10: After reset, busy, bus error, retry, event and interrupt are 0, and the slot position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the sticky flags when high at a clock edge |
| bus_busy | output | 1 | Bus-busy flag |
| slot_pos | output | $clog2(PULSES+1) | Pulse position inside the current slot, 0 to 9 |
| bus_err | output | 1 | Sticky misplaced-condition error |
| retry_hint | output | 1 | Sticky NACK or busy-drop report |
| event_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong slot position has two visible effects. It shows directly on `slot_pos` one clock after the SCL rise that produced it. It also moves the boundary between silent first-pulse handling and a flagged error, so a sweep that injects each condition at every position exposes an off-by-one on the next clock. A lost busy state or a stale pre-edge line sample shows up on `bus_busy` and `bus_err` one clock after the condition. A clear that fails, or that beats a same-cycle set, leaves the sticky flags wrong until the next clear.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
  } line_evt_t;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_IDLE,
    CL_LEGAL,
    CL_FIRST,
    CL_ERROR
  } cond_cls_t;

endpackage

// File: rtl/i2cmon_cond_det.sv
module i2cmon_cond_det
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl,
  input  logic      sda,
  output line_evt_t evt
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl;
    sda_d = sda;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    evt.start = scl_q & scl & sda_q & ~sda;
    evt.stop  = scl_q & scl & ~sda_q & sda;
    evt.rise  = ~scl_q & scl;
  end

endmodule

// File: rtl/i2cmon_slot_ctr.sv
module i2cmon_slot_ctr
  import i2cmon_pkg::*;
#(
  parameter  int PULSES = 9,
  localparam int CW     = $clog2(PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  line_evt_t     evt,
  input  logic          sda,
  output logic          busy,
  output logic [CW-1:0] pos,
  output cond_cls_t     cls,
  output logic          nack
);

  localparam logic [CW-1:0] LAST = CW'(PULSES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          busy_q, busy_d;
  logic [CW-1:0] pos_q, pos_d;
  logic          ena;
  logic          cond;

  always_comb begin
    cond = evt.start | evt.stop;
    if (!cond)                cls = CL_NONE;
    else if (!busy_q)         cls = CL_IDLE;
    else if (pos_q == '0)     cls = CL_LEGAL;
    else if (pos_q == ONE)    cls = CL_FIRST;
    else                      cls = CL_ERROR;
  end

  always_comb begin
    pos_d  = pos_q;
    busy_d = busy_q;
    unique case (cls)
      CL_NONE:  if (evt.rise) pos_d = (pos_q == LAST) ? ONE : pos_q + ONE;
      CL_IDLE:  if (evt.start) begin busy_d = 1'b1; pos_d = '0; end
      CL_LEGAL,
      CL_ERROR: begin busy_d = evt.start; pos_d = '0; end
      CL_FIRST: busy_d = 1'b0;
      default:  ;
    endcase
    ena  = (cls != CL_NONE) | evt.rise;
    nack = busy_q & evt.rise & (pos_q == LAST - ONE) & sda;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (ena) begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
    end
  end

  assign busy = busy_q;
  assign pos  = pos_q;

  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.rise && pos_q == LAST) |=> (pos_q == ONE));
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.start && !(busy_q && pos_q == ONE)) |=> (busy_q && pos_q == '0));
  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> !busy_q);
  p_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pos_q == ONE && (evt.start || evt.stop)) |=> (!busy_q && pos_q == ONE));

endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cond_cls_t cls,
  input  logic      start,
  input  logic      nack,
  input  logic      clr,
  input  logic      irq_en,
  output logic      bus_err,
  output logic      retry,
  output logic      evt_flag,
  output logic      irq
);

  logic err_q, err_d, retry_q, retry_d, evt_q, evt_d;
  logic err_set, retry_set, ena;

  always_comb begin
    err_set   = (cls == CL_ERROR);
    retry_set = nack | ((cls == CL_FIRST) & start);
    err_d     = err_set   | (err_q   & ~clr);
    retry_d   = retry_set | (retry_q & ~clr);
    evt_d     = err_set | retry_set | (evt_q & ~clr);
    ena       = err_set | retry_set | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      retry_q <= 1'b0;
      evt_q   <= 1'b0;
    end else if (ena) begin
      err_q   <= err_d;
      retry_q <= retry_d;
      evt_q   <= evt_d;
    end
  end

  assign bus_err  = err_q;
  assign retry    = retry_q;
  assign evt_flag = evt_q;
  assign irq      = evt_q & irq_en;

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr) |=> err_q);
  p_err_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> evt_q);
  p_first_noerr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CL_FIRST && !err_q) |=> !err_q);

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter  int PULSES = 9,
  localparam int CW     = $clog2(PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          bus_busy,
  output logic [CW-1:0] slot_pos,
  output logic          bus_err,
  output logic          retry_hint,
  output logic          event_flag,
  output logic          irq
);

  logic      rst_meta, rst_int_n;
  line_evt_t lev;
  cond_cls_t cls;
  logic      nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  i2cmon_cond_det u_det (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl   (scl_in),
    .sda   (sda_in),
    .evt   (lev)
  );

  i2cmon_slot_ctr #(.PULSES(PULSES)) u_slot (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (lev),
    .sda   (sda_in),
    .busy  (bus_busy),
    .pos   (slot_pos),
    .cls   (cls),
    .nack  (nack)
  );

  i2cmon_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cls      (cls),
    .start    (lev.start),
    .nack     (nack),
    .clr      (flag_clr),
    .irq_en   (irq_en),
    .bus_err  (bus_err),
    .retry    (retry_hint),
    .evt_flag (event_flag),
    .irq      (irq)
  );

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!irq_en |-> !irq) and (irq_en && event_flag |-> irq));

endmodule

// File: tb/sim_i2c_bus_monitor.sv
`timescale 1ns/1ps
module sim_i2c_bus_monitor;

  logic       clk = 1'b0;
  logic       rst_n, scl_in, sda_in, irq_en, flag_clr;
  logic       bus_busy, bus_err, retry_hint, event_flag, irq;
  logic [3:0] slot_pos;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  i2c_bus_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .irq_en(irq_en), .flag_clr(flag_clr), .bus_busy(bus_busy),
    .slot_pos(slot_pos), .bus_err(bus_err), .retry_hint(retry_hint),
    .event_flag(event_flag), .irq(irq)
  );

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic d);
    scl_in = s;
    sda_in = d;
    @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
  endtask

  task automatic start_idle();
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
  endtask

  task automatic to_idle_and_clear();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R7 err cleared", bus_err, 0);
    check("R2 busy after stop", bus_busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; irq_en = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 busy", bus_busy, 0);
    check("R10 pos", slot_pos, 0);
    check("R10 err", bus_err, 0);
    check("R10 retry", retry_hint, 0);
    check("R10 evt", event_flag, 0);
    check("R10 irq", irq, 0);

    // R9 idle stop is ignored, idle start is clean
    drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    check("R9 idle stop busy", bus_busy, 0);
    check("R9 idle stop err", bus_err, 0);
    start_idle();
    check("R1 start busy", bus_busy, 1);
    check("R1 start pos", slot_pos, 0);
    check("R9 idle start err", bus_err, 0);

    // R3 pulse counting across slot wraps
    for (int n = 1; n <= 20; n++) begin
      clock_bit(1'b0);
      check("R3 slot position", slot_pos, ((n - 1) % 9) + 1);
    end
    check("R3 no err while counting", bus_err, 0);
    check("R8 no retry with ack", retry_hint, 0);
    to_idle_and_clear();

    // R8 NACK on ninth pulse
    start_idle();
    for (int n = 1; n <= 8; n++) clock_bit(1'b0);
    clock_bit(1'b1);
    check("R8 nack retry", retry_hint, 1);
    check("R8 nack evt", event_flag, 1);
    check("R8 nack no err", bus_err, 0);
    check("R3 pos at ack", slot_pos, 9);
    // normal stop after the byte lands on pulse 1
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    check("R2 stop after byte busy", bus_busy, 0);
    check("R5 stop after byte err", bus_err, 0);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R7 retry cleared", retry_hint, 0);
    check("R7 evt cleared", event_flag, 0);

    // R4 R5 R6 R8 R9 sweep of condition position, kind and enable
    for (int en = 0; en < 2; en++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int p = 0; p <= 9; p++) begin
          logic pre;
          int e_err, e_busy, e_pos, e_retry, e_evt;
          if (kind == 0 && p == 0) continue;
          irq_en = en[0];
          pre = (kind == 0);
          start_idle();
          if (p == 0) begin
            drive(1'b1, 1'b1);
          end else begin
            for (int b = 1; b < p; b++) clock_bit(1'b0);
            drive(1'b0, pre);
            drive(1'b1, pre);
            drive(1'b1, ~pre);
          end
          e_err   = (p >= 2) ? 1 : 0;
          e_busy  = (p >= 2 && kind == 0) ? 1 : 0;
          e_pos   = (p == 1) ? 1 : 0;
          e_retry = (kind == 0 && (p == 1 || p == 9)) ? 1 : 0;
          e_evt   = (e_err != 0 || e_retry != 0) ? 1 : 0;
          check("R4 R5 R9 sweep err", bus_err, e_err);
          check("R4 R5 R9 sweep busy", bus_busy, e_busy);
          check("R4 R5 sweep pos", slot_pos, e_pos);
          check("R8 sweep retry", retry_hint, e_retry);
          check("R4 sweep evt", event_flag, e_evt);
          check("R6 sweep irq", irq, e_evt & en);
          to_idle_and_clear();
        end
      end
    end

    // R7 hold over time and set beating a simultaneous clear
    irq_en = 1'b1;
    start_idle();
    for (int b = 1; b < 5; b++) clock_bit(1'b0);
    drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
    repeat (5) @(negedge clk);
    check("R7 err held", bus_err, 1);
    check("R6 irq held", irq, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R7 clear", bus_err, 0);
    start_idle();
    for (int b = 1; b < 5; b++) clock_bit(1'b0);
    drive(1'b0, 1'b0); drive(1'b1, 1'b0);
    flag_clr = 1'b1;
    drive(1'b1, 1'b1);
    flag_clr = 1'b0;
    check("R7 set wins over clear", bus_err, 1);
    check("R7 evt set wins", event_flag, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule